// File: doc/BRIEF.md
# Pipelined Converter Output Word Assembler with Dither Removal

This block sits at the digital end of a five-stage pipelined analog-to-digital converter. Each stage delivers its raw comparator code on a separate cycle, because the analog residue takes one cycle to travel from one stage to the next. The block holds every code back until the codes of the same sample are all present. It then adds them with overlapping binary weights and removes the pseudo-random dither that the analog front end injected into the first stage for that sample. Finally it clamps the result to a 12-bit word.

There are five stages. The first stage is a 5-bit-wide code from a 16-threshold quantizer, so its code value runs from 0 to 16, and its residue gain is 4. Three middle stages follow, each with a 3-bit code and a gain of 4. The last stage is a 3-bit flash. The 7-bit dither code and its enable arrive on the same cycle as the first-stage code of the sample they belong to. One dither step is 1/128 of a first-stage step.

Top module: `pipe_code_combiner`

## Requirements
- R1: For a complete sample, the output word is s0*256 + s1*64 + s2*16 + s3*4 + f - 512 - D, clamped to the range 0..4095. Here s0 is the first-stage code, s1..s3 are the middle-stage codes, f is the flash code and D is the dither term.
- R2: A sample's stage-k code (k = 1, 2, 3, and 4 for the flash) and its valid are taken k cycles after the clock edge that takes its first-stage code. The dither code and enable are taken on that same first edge. Codes presented on cycles whose valid is low have no effect on any output.
- R3: If the first-stage code of a sample is taken at edge n, then out_vld is high and out_word holds that sample's result after edge n+4. Samples presented on consecutive cycles produce outputs on consecutive cycles.
- R4: With the enable set, the dither term D equals twice the 7-bit dither code.
- R5: With the enable clear for a sample, D is zero for that sample.
- R6: A combined value above 4095 is output as 4095.
- R7: A combined value below 0 is output as 0.
- R8: If any one of the five stage valids of a sample is low, no output is produced in that sample's output slot (out_vld low).
- R9: While out_vld is low, out_word keeps its last value.
- R10: While reset is asserted, and right after it, out_vld is 0 and out_word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s0_code | input | 5 | First-stage code, 0..16 |
| s0_vld | input | 1 | First-stage code valid |
| s1_code | input | 3 | Second-stage code |
| s1_vld | input | 1 | Second-stage valid |
| s2_code | input | 3 | Third-stage code |
| s2_vld | input | 1 | Third-stage valid |
| s3_code | input | 3 | Fourth-stage code |
| s3_vld | input | 1 | Fourth-stage valid |
| fl_code | input | 3 | Final flash code |
| fl_vld | input | 1 | Final flash valid |
| dith_code | input | 7 | Dither injected into the first stage for this sample |
| dith_en | input | 1 | Dither subtraction enable for this sample |
| out_word | output | 12 | Corrected output word |
| out_vld | output | 1 | Output word valid |

## Verification
The hardest case to reach is a sample that is broken in only one stage while its neighbours in the pipeline stay complete. Because of the staggered arrival, the cycle that carries the missing strobe also carries valid codes that belong to four other samples. The bench describes each sample as one record of five codes plus its dither. It scatters each record across five cycles at the required offsets, leaves out one stage's strobe for selected samples inside a dense burst, and fills every unclaimed code slot with random junk. Samples are also chosen so that the clamp is driven past both ends, and so that the dither and its enable change from one sample to the next.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    // log2 of the interstage residue gain used by every stage but the last
    localparam int GAIN_BITS = 2;

    // Weight shift of stage idx (0 = first stage, n_mid+1 = flash)
    function automatic int stage_shift(input int idx, input int n_mid);
        return (n_mid + 1 - idx) * GAIN_BITS;
    endfunction

endpackage

// File: rtl/cc_delay.sv
module cc_delay #(
    parameter int W     = 4,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] tap_q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tap_q[k] <= '0;
            end else if (k == 0) begin
                tap_q[k] <= din;
            end else begin
                tap_q[k] <= tap_q[(k == 0) ? 0 : k-1];
            end
        end
    end

    assign dout = tap_q[DEPTH-1];

endmodule

// File: rtl/cc_weigh.sv
module cc_weigh
    import pcc_pkg::*;
#(
    parameter int S0_W        = 5,
    parameter int MID_W       = 3,
    parameter int FL_W        = 3,
    parameter int DITH_W      = 7,
    parameter int NUM_MID     = 3,
    parameter int SUM_W       = 15,
    parameter int CODE_OFFSET = 512
) (
    input  logic [S0_W-1:0]               s0_code,
    input  logic [NUM_MID-1:0][MID_W-1:0] mid_code,
    input  logic [FL_W-1:0]               fl_code,
    input  logic [DITH_W-1:0]             dith_code,
    input  logic                          dith_en,
    output logic signed [SUM_W-1:0]       sum
);

    localparam int S0_SHIFT   = stage_shift(0, NUM_MID);
    localparam int DITH_SHIFT = S0_SHIFT - DITH_W;

    logic signed [SUM_W-1:0] acc;

    always_comb begin
        acc = $signed(SUM_W'(s0_code)) << S0_SHIFT;
        for (int j = 0; j < NUM_MID; j++) begin
            acc = acc + ($signed(SUM_W'(mid_code[j])) << stage_shift(j + 1, NUM_MID));
        end
        acc = acc + $signed(SUM_W'(fl_code));
        acc = acc - $signed(SUM_W'(CODE_OFFSET));
        if (dith_en) begin
            acc = acc - ($signed(SUM_W'(dith_code)) << DITH_SHIFT);
        end
        sum = acc;
    end

endmodule

// File: rtl/cc_out_stage.sv
module cc_out_stage #(
    parameter int OUT_W = 12,
    parameter int SUM_W = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic signed [SUM_W-1:0] sum,
    output logic [OUT_W-1:0]        out_word,
    output logic                    out_vld
);

    localparam int TOP_INT = (1 << OUT_W) - 1;

    logic [OUT_W-1:0] clamped;

    always_comb begin
        if (sum < 0) begin
            clamped = '0;
        end else if (sum > $signed(SUM_W'(TOP_INT))) begin
            clamped = '1;
        end else begin
            clamped = sum[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word <= '0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_word <= clamped;
            end
        end
    end

    // R6: an overrange sum lands on the top code
    assert_clamp_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (sum > $signed(SUM_W'(TOP_INT)))) |=> (out_word == OUT_W'(TOP_INT)));

    // R7: a negative sum lands on zero
    assert_clamp_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (sum < 0)) |=> (out_word == '0));

    // R9: no update without a complete sample
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld) |=> $stable(out_word));

endmodule

// File: rtl/pipe_code_combiner.sv
module pipe_code_combiner
    import pcc_pkg::*;
#(
    parameter int S0_W        = 5,
    parameter int MID_W       = 3,
    parameter int FL_W        = 3,
    parameter int DITH_W      = 7,
    parameter int OUT_W       = 12,
    parameter int CODE_OFFSET = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [S0_W-1:0]   s0_code,
    input  logic              s0_vld,
    input  logic [MID_W-1:0]  s1_code,
    input  logic              s1_vld,
    input  logic [MID_W-1:0]  s2_code,
    input  logic              s2_vld,
    input  logic [MID_W-1:0]  s3_code,
    input  logic              s3_vld,
    input  logic [FL_W-1:0]   fl_code,
    input  logic              fl_vld,
    input  logic [DITH_W-1:0] dith_code,
    input  logic              dith_en,
    output logic [OUT_W-1:0]  out_word,
    output logic              out_vld
);

    localparam int NUM_MID  = 3;
    localparam int S0_SHIFT = stage_shift(0, NUM_MID);
    localparam int SUM_W    = S0_W + S0_SHIFT + 2;
    localparam int S0_LAT   = NUM_MID + 1;
    localparam int S0_BUS_W = S0_W + DITH_W + 2;

    // First stage plus dither travel together for S0_LAT cycles
    logic [S0_BUS_W-1:0] s0_bus_al;
    logic [S0_W-1:0]     s0_code_al;
    logic                s0_vld_al;
    logic [DITH_W-1:0]   dith_al;
    logic                dith_en_al;

    cc_delay #(.W(S0_BUS_W), .DEPTH(S0_LAT)) u_s0_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({dith_en, dith_code, s0_vld, s0_code}),
        .dout (s0_bus_al)
    );

    assign {dith_en_al, dith_al, s0_vld_al, s0_code_al} = s0_bus_al;

    // Middle stages: stage j+1 waits NUM_MID-j cycles
    logic [NUM_MID-1:0][MID_W-1:0] mid_code_in;
    logic [NUM_MID-1:0]            mid_vld_in;
    logic [NUM_MID-1:0][MID_W-1:0] mid_code_al;
    logic [NUM_MID-1:0]            mid_vld_al;

    assign mid_code_in = {s3_code, s2_code, s1_code};
    assign mid_vld_in  = {s3_vld, s2_vld, s1_vld};

    for (genvar j = 0; j < NUM_MID; j++) begin : g_mid
        logic [MID_W:0] bus_al;
        cc_delay #(.W(MID_W + 1), .DEPTH(NUM_MID - j)) u_mid_dly (
            .clk  (clk),
            .rst_n(rst_n),
            .din  ({mid_vld_in[j], mid_code_in[j]}),
            .dout (bus_al)
        );
        assign mid_code_al[j] = bus_al[MID_W-1:0];
        assign mid_vld_al[j]  = bus_al[MID_W];
    end

    // Flash is the last arrival and needs no delay
    logic all_vld;
    assign all_vld = s0_vld_al & (&mid_vld_al) & fl_vld;

    logic signed [SUM_W-1:0] sum;

    cc_weigh #(
        .S0_W       (S0_W),
        .MID_W      (MID_W),
        .FL_W       (FL_W),
        .DITH_W     (DITH_W),
        .NUM_MID    (NUM_MID),
        .SUM_W      (SUM_W),
        .CODE_OFFSET(CODE_OFFSET)
    ) u_weigh (
        .s0_code  (s0_code_al),
        .mid_code (mid_code_al),
        .fl_code  (fl_code),
        .dith_code(dith_al),
        .dith_en  (dith_en_al),
        .sum      (sum)
    );

    cc_out_stage #(.OUT_W(OUT_W), .SUM_W(SUM_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (all_vld),
        .sum     (sum),
        .out_word(out_word),
        .out_vld (out_vld)
    );

    // R3: every output traces back to a first-stage strobe S0_LAT+1 edges earlier
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(s0_vld, 5));

    // R8: a missing flash strobe kills the slot
    assert_flash_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_vld) |=> (!out_vld));

endmodule

// File: tb/pipe_code_combiner_tb.sv
module pipe_code_combiner_tb;

    localparam int N  = 310;
    localparam int NA = N + 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] s0_code = '0;
    logic       s0_vld = 1'b0;
    logic [2:0] s1_code = '0, s2_code = '0, s3_code = '0, fl_code = '0;
    logic       s1_vld = 1'b0, s2_vld = 1'b0, s3_vld = 1'b0, fl_vld = 1'b0;
    logic [6:0] dith_code = '0;
    logic       dith_en = 1'b0;
    logic [11:0] out_word;
    logic        out_vld;

    always #5 clk = ~clk;

    pipe_code_combiner u_dut (
        .clk(clk), .rst_n(rst_n),
        .s0_code(s0_code), .s0_vld(s0_vld),
        .s1_code(s1_code), .s1_vld(s1_vld),
        .s2_code(s2_code), .s2_vld(s2_vld),
        .s3_code(s3_code), .s3_vld(s3_vld),
        .fl_code(fl_code), .fl_vld(fl_vld),
        .dith_code(dith_code), .dith_en(dith_en),
        .out_word(out_word), .out_vld(out_vld)
    );

    // Per-cycle stimulus tables: index = clock edge that takes the value
    int    cd [5][NA];
    bit    vd [5][NA];
    int    dz [NA];
    bit    ez [NA];
    bit    dropped [NA];
    string wtag [NA];

    int unsigned seed = 32'h1234_5678;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int exp_word = 0;

    function automatic int rnd(input int m);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'h7fff) % m;
    endfunction

    task automatic put_sample(input int i, input int c0, input int c1, input int c2,
                              input int c3, input int cf, input int d, input bit en,
                              input int skip, input string tag);
        int cs [5];
        cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3; cs[4] = cf;
        for (int k = 0; k < 5; k++) begin
            if (k != skip) begin
                cd[k][i+k] = cs[k];
                vd[k][i+k] = 1'b1;
            end
        end
        dz[i] = d;
        ez[i] = en;
        wtag[i] = tag;
        if (skip >= 0) dropped[i+4] = 1'b1;
    endtask

    task automatic put_random(input int i, input bit en, input int skip, input string tag);
        put_sample(i, rnd(17), rnd(8), rnd(8), rnd(8), rnd(8), rnd(128), en, skip, tag);
    endtask

    task automatic drive(input int i);
        s0_code = 5'(cd[0][i]); s0_vld = vd[0][i];
        s1_code = 3'(cd[1][i]); s1_vld = vd[1][i];
        s2_code = 3'(cd[2][i]); s2_vld = vd[2][i];
        s3_code = 3'(cd[3][i]); s3_vld = vd[3][i];
        fl_code = 3'(cd[4][i]); fl_vld = vd[4][i];
        dith_code = 7'(dz[i]);  dith_en = ez[i];
    endtask

    task automatic cmp(input string req, input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
        end
    endtask

    // Reference: result of edge n, from the scattered sample records
    task automatic check_edge(input int n);
        bit ev;
        int raw;
        string vt;
        ev = (n >= 4) && vd[0][n-4] && vd[1][n-3] && vd[2][n-2] && vd[3][n-1] && vd[4][n];
        if (ev) begin
            raw = cd[0][n-4]*256 + cd[1][n-3]*64 + cd[2][n-2]*16 + cd[3][n-1]*4 + cd[4][n] - 512;
            if (ez[n-4]) raw = raw - 2*dz[n-4];
            if (raw < 0) raw = 0;
            if (raw > 4095) raw = 4095;
            exp_word = raw;
        end
        vt = dropped[n] ? "R8" : "R3";
        cmp(vt, int'(out_vld), int'(ev), "out_vld");
        cmp(ev ? wtag[n-4] : "R9", int'(out_word), exp_word, "out_word");
    endtask

    initial begin
        for (int i = 0; i < NA; i++) begin
            for (int k = 0; k < 5; k++) begin
                cd[k][i] = (k == 0) ? rnd(32) : rnd(8);
                vd[k][i] = 1'b0;
            end
            dz[i] = rnd(128);
            ez[i] = rnd(2) == 1;
            dropped[i] = 1'b0;
            wtag[i] = "R1";
        end
        // Dense burst, dither on (R1)
        for (int i = 2; i < 82; i++) put_random(i, 1'b1, -1, "R1");
        // Sparse samples with junk between them, enable alternating (R2, R5)
        for (int i = 90; i < 150; i += 2) begin
            if (i % 4 == 0) put_random(i, 1'b1, -1, "R2");
            else            put_random(i, 1'b0, -1, "R5");
        end
        // Clamp ends and exact dither arithmetic
        put_sample(160, 16, 7, 7, 7, 7, 0, 1'b1, -1, "R6");   // 4179 -> 4095
        put_sample(161, 0, 0, 0, 0, 0, 127, 1'b1, -1, "R7");  // -766 -> 0
        put_sample(162, 4, 0, 0, 0, 0, 127, 1'b1, -1, "R4");  // 258
        put_sample(163, 4, 0, 0, 0, 0, 127, 1'b0, -1, "R5");  // 512
        put_sample(164, 8, 0, 0, 0, 0, 64, 1'b1, -1, "R4");   // 1408
        // Dense burst with single-stage strobe drops (R8)
        for (int i = 170; i < 190; i++) begin
            if (i == 172 || i == 176 || i == 180 || i == 184)
                put_random(i, 1'b1, (i - 170) % 5, "R8");
            else
                put_random(i, 1'b1, -1, "R1");
        end
        // Random occupancy
        for (int i = 200; i < 300; i++) begin
            if (rnd(3) != 0) begin
                if (rnd(2) == 1) put_random(i, 1'b1, -1, "R2");
                else             put_random(i, 1'b0, -1, "R5");
            end
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R10", int'(out_vld), 0, "out_vld in reset");
        cmp("R10", int'(out_word), 0, "out_word in reset");
        rst_n = 1'b1;
        cmp("R10", int'(out_vld), 0, "out_vld after reset");
        for (int i = 0; i < N; i++) begin
            drive(i);
            @(negedge clk);
            check_edge(i);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule